// File: doc/BRIEF.md
# MDIO Management Controller with PHY Scan

This block is the station-management master for external Ethernet PHYs. It builds Clause 22 read and write frames, produces the MDC clock from the system clock, and drives MDIO through a tri-state output with an output enable. Software starts a one-off transfer with a rising edge on a write or read trigger. The engine takes the PHY address, the register address and, for writes, a 16-bit data word. It reports the data read back, the PHY address that data came from, a busy flag and a sticky completion flag.

In scan mode the engine polls one register without any software action. It reads back to back, starting at a programmed base PHY address. When address stepping is also on, each read moves to the next PHY. After PHY 31 the address returns to the base. The 32-bit preamble can be left out for PHYs that accept suppressed preamble.

Top module: `mdio_scan_ctrl`

## Requirements
- R1: A rising edge on `wr_go` while idle sends a write frame, MSB first: start `01`, opcode `01`, 5-bit PHY address, 5-bit register address, turnaround `10` driven by the engine, then the 16 bits of `wdata`.
- R2: A rising edge on `rd_go` while idle sends a read frame with opcode `10`. `mdio_oe` is low from the first turnaround bit to the end of the frame. The 16 data bits sampled from `mdio_i` are placed in `rdata`, and the frame's PHY address is placed in `rphy`.
- R3: Trigger edges that arrive while `busy` is high start nothing. They produce no `cmd_ack`, and no second frame follows.
- R4: `cmd_ack` is high for exactly one cycle when a trigger is accepted, so the requester can clear its trigger bit.
- R5: With `no_pre` low, 32 ones precede the start bits (64 MDC periods per frame). With `no_pre` high, the frame is 32 MDC periods long.
- R6: MDC has a half period of `DIV` system clocks and stays low while idle. MDIO output changes on MDC falling edges and input is sampled on rising edges. A frame of N bits keeps `busy` high for N·2·DIV clocks.
- R7: `busy` rises when a frame starts and falls after the last bit's falling MDC edge. `done` is set when every frame completes and stays set until `done_clr` is pulsed.
- R8: While `scan_en` is high, reads run back to back. Without `scan_step`, every read uses `phy_base`. When `scan_en` is cleared, the frame in progress completes and no further read starts.
- R9: With `scan_en` and `scan_step` both high, scan reads go to base, base+1, and so on up to 31, then return to base. `scan_step` alone starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_go | input | 1 | Write trigger, acts on its rising edge |
| rd_go | input | 1 | Read trigger, acts on its rising edge |
| scan_en | input | 1 | Continuous read polling |
| scan_step | input | 1 | Step the PHY address after each scan read |
| no_pre | input | 1 | Leave out the preamble |
| phy_base | input | 5 | PHY address, or base address for a scan |
| reg_sel | input | 5 | PHY register address |
| wdata | input | 16 | Data for write frames |
| done_clr | input | 1 | Clears `done` |
| mdio_i | input | 1 | MDIO pin input |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO pin output value |
| mdio_oe | output | 1 | MDIO output enable |
| cmd_ack | output | 1 | One-cycle trigger acceptance pulse |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Sticky completion flag |
| rdata | output | 16 | Last read data |
| rphy | output | 5 | PHY address of `rdata` |

## Verification
The bench uses a small PHY responder that decodes each address and returns data built from it. A design that misplaced the turnaround release, or sampled on the wrong MDC edge, would therefore return shifted data. The bench counts MDC periods and busy clocks to catch a preamble that is dropped or sent wrongly. It pulses a write trigger in the middle of a read; a design that queued that trigger would send a second frame or raise `cmd_ack`. It also runs scans from base 29 to check the wrap after PHY 31, checks that a scan stops cleanly when `scan_en` is cleared, and checks that stepping alone never starts traffic.

// File: rtl/mdio_scan_ctrl.sv
module mdio_scan_ctrl #(
  parameter int DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_go,
  input  logic        rd_go,
  input  logic        scan_en,
  input  logic        scan_step,
  input  logic        no_pre,
  input  logic [4:0]  phy_base,
  input  logic [4:0]  reg_sel,
  input  logic [15:0] wdata,
  input  logic        done_clr,
  input  logic        mdio_i,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        cmd_ack,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdata,
  output logic [4:0]  rphy
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic [5:0]    idx;
  logic [31:0]   frame;
  logic [15:0]   sh;
  logic [4:0]    addr;
  logic          is_rd, pre, scan_run, wr_q, rd_q;

  wire       wr_edge  = wr_go & ~wr_q;
  wire       rd_edge  = rd_go & ~rd_q;
  wire       start_wr = !busy && wr_edge;
  wire       start_rd = !busy && !wr_edge && (rd_edge || scan_en);
  wire [4:0] scan_nxt = (!scan_run || !scan_step) ? phy_base :
                        (addr == 5'd31) ? phy_base : addr + 5'd1;
  wire [4:0] sa       = (start_wr || rd_edge) ? phy_base : scan_nxt;

  wire [5:0] last    = pre ? 6'd63 : 6'd31;
  wire       in_pre  = pre && (idx < 6'd32);
  wire [5:0] pos     = pre ? idx - 6'd32 : idx;
  wire       half    = (cnt == CW'(DIV - 1));
  wire       rd_tail = is_rd && !in_pre && (pos >= 6'd14);

  assign mdio_oe = busy && !rd_tail;
  assign mdio_o  = busy && (in_pre || frame[5'd31 - pos[4:0]]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; idx <= '0; frame <= '0; sh <= '0; addr <= '0;
      is_rd <= 1'b0; pre <= 1'b0; scan_run <= 1'b0;
      wr_q <= 1'b0; rd_q <= 1'b0;
      mdc <= 1'b0; cmd_ack <= 1'b0; busy <= 1'b0; done <= 1'b0;
      rdata <= '0; rphy <= '0;
    end else begin
      wr_q    <= wr_go;
      rd_q    <= rd_go;
      cmd_ack <= 1'b0;
      if (done_clr) done <= 1'b0;
      if (!busy) begin
        if (!scan_en) scan_run <= 1'b0;
        if (start_wr || start_rd) begin
          busy     <= 1'b1;
          mdc      <= 1'b0;
          cnt      <= '0;
          idx      <= '0;
          pre      <= !no_pre;
          is_rd    <= start_rd;
          addr     <= sa;
          frame    <= {2'b01, start_rd ? 2'b10 : 2'b01, sa, reg_sel,
                       start_rd ? 2'b00 : 2'b10, start_rd ? 16'h0000 : wdata};
          cmd_ack  <= start_wr || rd_edge;
          scan_run <= start_rd && !rd_edge;
        end
      end else if (half) begin
        cnt <= '0;
        if (!mdc) begin
          mdc <= 1'b1;
          if (rd_tail && pos >= 6'd16) sh <= {sh[14:0], mdio_i};
        end else begin
          mdc <= 1'b0;
          if (idx == last) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (is_rd) begin
              rdata <= sh;
              rphy  <= addr;
            end
          end else begin
            idx <= idx + 6'd1;
          end
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

module mdio_scan_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic mdc,
  input logic mdio_oe,
  input logic cmd_ack,
  input logic done,
  input logic done_clr
);
  AST_ACK_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> busy);                                          // R4
  AST_NO_ACK_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !cmd_ack);                        // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));                              // R6
  AST_DONE_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);                                      // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> done);                              // R7
endmodule

bind mdio_scan_ctrl mdio_scan_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mdc(mdc), .mdio_oe(mdio_oe),
  .cmd_ack(cmd_ack), .done(done), .done_clr(done_clr)
);

// File: tb/mdio_scan_ctrl_bench.sv
module mdio_scan_ctrl_bench;
  localparam int DIV = 2;

  logic clk = 0, rst_n = 0;
  logic wr_go = 0, rd_go = 0, scan_en = 0, scan_step = 0, no_pre = 0, done_clr = 0;
  logic [4:0] phy_base = 0, reg_sel = 0;
  logic [15:0] wdata = 0;
  logic mdio_i = 0;
  logic mdc, mdio_o, mdio_oe, cmd_ack, busy, done;
  logic [15:0] rdata;
  logic [4:0] rphy;

  int checks = 0, errors = 0;
  int rises = 0, ocnt = 0, k = 0;
  logic [63:0] cap = '0;
  logic [15:0] resp = '0;

  mdio_scan_ctrl #(.DIV(DIV)) u_mdio_scan_ctrl (.*);

  always #10 clk = ~clk;

  function automatic logic [15:0] phy_ans(input logic [4:0] p, input logic [4:0] r);
    return {1'b1, p, r, 5'b10011};
  endfunction

  always @(posedge mdc) begin
    rises++;
    if (mdio_oe) begin
      cap = {cap[62:0], mdio_o};
      ocnt++;
    end else begin
      k++;
      if (k >= 2 && k <= 17) #1 mdio_i = resp[17-k];
    end
  end

  always @(negedge mdio_oe) if (busy) begin
    resp = phy_ans(cap[9:5], cap[4:0]);
    k = 0;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_frame();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic run(input logic np, input logic op, input logic [4:0] p,
                     input logic [4:0] r, input logic [15:0] d);
    int r0, o0, bc, bits;
    @(negedge clk);
    no_pre = np; phy_base = p; reg_sel = r; wdata = d;
    r0 = rises; o0 = ocnt;
    if (op) rd_go = 1; else wr_go = 1;
    @(negedge clk);
    chk("R4 ack", cmd_ack, 1);
    @(negedge clk);
    chk("R4 ack width", cmd_ack, 0);
    wr_go = 0; rd_go = 0; bc = 2;
    while (busy) begin @(negedge clk); if (busy) bc++; end
    bits = np ? 32 : 64;
    chk("R6 busy clocks", bc, bits * 2 * DIV);
    chk("R5 mdc periods", rises - r0, bits);
    chk("R7 done", done, 1);
    if (op) begin
      chk("R2 driven bits", ocnt - o0, bits - 18);
      chk("R2 header", cap[13:0], {4'b0110, p, r});
      chk("R2 rdata", rdata, phy_ans(p, r));
      chk("R2 rphy", rphy, p);
    end else begin
      chk("R1 driven bits", ocnt - o0, bits);
      chk("R1 frame", cap[31:0], {4'b0101, p, r, 2'b10, d});
      if (!np) chk("R5 preamble", cap[63:32], 32'hFFFF_FFFF);
    end
  endtask

  localparam logic [27:0] VEC [6] = '{
    {1'b0, 1'b0, 5'd3,  5'd0,  16'hA5C3},
    {1'b0, 1'b1, 5'd3,  5'd1,  16'h0000},
    {1'b1, 1'b0, 5'd17, 5'd4,  16'h8001},
    {1'b1, 1'b1, 5'd31, 5'd31, 16'h0000},
    {1'b0, 1'b1, 5'd0,  5'd2,  16'h0000},
    {1'b0, 1'b0, 5'd12, 5'd9,  16'hFFFF}
  };

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R7 reset busy", busy, 0);
    chk("R6 reset mdc", mdc, 0);
    chk("R2 reset oe", mdio_oe, 0);
    chk("R7 reset done", done, 0);
    chk("R2 reset rdata", rdata, 0);

    foreach (VEC[i]) run(VEC[i][27], VEC[i][26], VEC[i][25:21], VEC[i][20:16], VEC[i][15:0]);

    @(negedge clk); done_clr = 1;
    @(negedge clk); done_clr = 0;
    chk("R7 done cleared", done, 0);

    // R3: write edge during a read is dropped
    begin
      int o0;
      @(negedge clk);
      no_pre = 0; phy_base = 5'd9; reg_sel = 5'd6; o0 = ocnt;
      rd_go = 1;
      @(negedge clk); @(negedge clk); rd_go = 0;
      repeat (40) @(negedge clk);
      wr_go = 1;
      @(negedge clk);
      chk("R3 no ack while busy", cmd_ack, 0);
      while (busy) @(negedge clk);
      wr_go = 0;
      repeat (10) @(negedge clk);
      chk("R3 no second frame", busy, 0);
      chk("R3 single frame bits", ocnt - o0, 46);
      chk("R3 read intact", rdata, phy_ans(5'd9, 5'd6));
    end

    // R9: step alone starts nothing
    @(negedge clk); scan_step = 1;
    repeat (30) @(negedge clk);
    chk("R9 step without scan", busy, 0);

    // R8: scan without stepping
    @(negedge clk); scan_step = 0; phy_base = 5'd7; reg_sel = 5'd3; no_pre = 1; scan_en = 1;
    for (int n = 0; n < 3; n++) begin
      wait_frame();
      chk("R8 scan fixed rphy", rphy, 5'd7);
      chk("R8 scan fixed rdata", rdata, phy_ans(5'd7, 5'd3));
    end
    scan_en = 0;
    repeat (30) @(negedge clk);
    chk("R8 scan stops", busy, 0);

    // R9: stepping scan wraps after 31
    @(negedge clk); phy_base = 5'd29; scan_step = 1; scan_en = 1;
    for (int n = 0; n < 4; n++) begin
      logic [4:0] ep;
      ep = (n == 3) ? 5'd29 : 5'(29 + n);
      wait_frame();
      if (n == 3) scan_en = 0;
      chk("R9 scan rphy", rphy, ep);
      chk("R9 scan rdata", rdata, phy_ans(ep, 5'd3));
    end
    repeat (30) @(negedge clk);
    chk("R8 scan stops after clear", busy, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule